// File: doc/BRIEF.md
# Hit-Limited Zero-Suppressing Level-1 Buffer

This block sits behind the time digitizers of a four-channel group. Each channel presents a hit flag and a 14-bit arrival time. Every fourth clock the block copies all four channels into a hold-shift stage. Over the next four cycles it presents the held hits one channel at a time. A per-channel limiter lets at most four hits per channel into each time window. Empty slots and hits over the limit are discarded. Each accepted hit is written as one 16-bit word into a circular memory of window blocks.

Time is cut into windows of 256 clocks. The write side fills one block per window and moves to the next block, modulo 16, at every window boundary. A spill-start pulse clears the window timing, the block index and all block contents. A trigger names a latency in windows. The reader then streams out every word stored in the two consecutive blocks it selects, and pulses a done flag at the end.

The hit inputs have no ready: a digitizer front end cannot wait, so the block samples them only on load cycles. The readout is a valid/ready stream. While `rd_valid` is high and `rd_ready` is low, the word is held unchanged. A word is consumed only on a cycle where both are high. `rd_valid` is never withdrawn before acceptance, except by `spill_start`.

Top module: `tdc_l1_buffer`

## Requirements
- R1: After reset, `rd_busy`, `rd_valid` and `rd_done` are low.
- R2: Edges are numbered k = 0, 1, 2, ... from the first edge after reset or after a `spill_start` edge. Hit inputs are sampled only at edges with k mod 4 = 3. Hits asserted at any other edge are never stored. A slot whose hit flag is low writes nothing.
- R3: At most 4 words per channel are stored in one window; further hits of that channel in the window are dropped.
- R4: A stored word is {channel[1:0], time[13:0]}. The channel number sits in bits 15:14 and the time in bits 13:0. Words of one load period are stored in channel order 0, 1, 2, 3, and within a block in arrival order.
- R5: A window lasts 256 clocks. At its end the write block index advances by one modulo 16. The newly entered block starts empty.
- R6: A trigger while idle captures latency L. Let W be the block being written at that edge. The reader outputs every word of block (W-L) mod 16, then every word of block (W-L+1) mod 16. It outputs exactly the stored number of words. `rd_valid` is low whenever `rd_busy` is low. L must lie in 1..14 for the selected blocks to stay intact during readout.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold. The reader advances one word per accepted handshake.
- R8: `rd_done` is a one-cycle pulse. It rises on the edge where `rd_busy` falls after the second block is exhausted.
- R9: A trigger while `rd_busy` is high is ignored.
- R10: `spill_start` clears the window timing, block index, hit limits, block contents and any readout in progress. No `rd_done` is given for the aborted readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spill_start | input | 1 | Synchronous restart of windows and contents |
| hit_vld | input | 4 | Per-channel hit flag |
| hit_time | input | 56 | Per-channel 14-bit time, channel c in bits 14c+13:14c |
| trig | input | 1 | Readout trigger |
| trig_lat | input | 4 | Trigger latency in windows |
| rd_ready | input | 1 | Readout sink ready |
| rd_valid | output | 1 | Readout word valid |
| rd_data | output | 16 | Readout word |
| rd_busy | output | 1 | Readout in progress |
| rd_done | output | 1 | Readout finished pulse |

## Verification
Dense random hits on all channels saturate the per-window limit. This separates a correct cap and channel ordering from off-by-one counters. A pattern that raises hits only on non-load cycles must leave its windows empty, which exposes a wrong sampling phase. Sparse hits with random back-pressure, overlapping triggers and several latencies check which block pair is chosen, word counts, stall holding and the ignored second trigger. A spill pulse in the middle of a readout checks the abort and the restart of block numbering.

// File: rtl/l1buf_pkg.sv
package l1buf_pkg;
  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_FIRST  = 2'd1,
    RD_SECOND = 2'd2
  } rd_state_e;
endpackage

// File: rtl/l1_hold_shift.sv
module l1_hold_shift #(
  parameter int NCH    = 4,
  parameter int TIME_W = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  load,
  input  logic [NCH-1:0]        in_vld,
  input  logic [NCH*TIME_W-1:0] in_time,
  output logic                  out_vld,
  output logic [TIME_W-1:0]     out_time
);
  for (genvar i = 0; i < NCH; i++) begin : g_slot
    logic              v;
    logic [TIME_W-1:0] t;
    logic              nxt_v;
    logic [TIME_W-1:0] nxt_t;
    if (i == NCH-1) begin : g_last
      assign nxt_v = 1'b0;
      assign nxt_t = '0;
    end else begin : g_mid
      assign nxt_v = g_slot[i+1].v;
      assign nxt_t = g_slot[i+1].t;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v <= 1'b0;
        t <= '0;
      end else if (clr) begin
        v <= 1'b0;
      end else if (load) begin
        v <= in_vld[i];
        t <= in_time[i*TIME_W +: TIME_W];
      end else begin
        v <= nxt_v;
        t <= nxt_t;
      end
    end
  end

  assign out_vld  = g_slot[0].v;
  assign out_time = g_slot[0].t;
endmodule

// File: rtl/l1_hit_limiter.sv
module l1_hit_limiter #(
  parameter int NCH     = 4,
  parameter int HIT_CAP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   slot_vld,
  input  logic [$clog2(NCH)-1:0] slot_ch,
  output logic                   wr_en
);
  localparam int CAP_W = $clog2(HIT_CAP + 1);

  logic [CAP_W-1:0] cnt_q [NCH];

  assign wr_en = slot_vld && (cnt_q[slot_ch] < CAP_W'(HIT_CAP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) cnt_q[c] <= '0;
    end else if (clr) begin
      for (int c = 0; c < NCH; c++) cnt_q[c] <= '0;
    end else if (wr_en) begin
      cnt_q[slot_ch] <= cnt_q[slot_ch] + CAP_W'(1);
    end
  end
endmodule

// File: rtl/l1_win_store.sv
module l1_win_store #(
  parameter int NBLK   = 16,
  parameter int WPB    = 16,
  parameter int WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      adv,
  input  logic                      wr_en,
  input  logic [WORD_W-1:0]         wr_word,
  input  logic [$clog2(NBLK)-1:0]   rd_blk,
  input  logic [$clog2(WPB+1)-1:0]  rd_idx,
  output logic [$clog2(NBLK)-1:0]   wr_blk,
  output logic [$clog2(WPB+1)-1:0]  wr_ptr,
  output logic [WORD_W-1:0]         rd_word,
  output logic [$clog2(WPB+1)-1:0]  rd_cnt
);
  localparam int BLK_W = $clog2(NBLK);
  localparam int IDX_W = $clog2(WPB);
  localparam int CNT_W = $clog2(WPB + 1);

  logic [WORD_W-1:0] mem   [NBLK][WPB];
  logic [CNT_W-1:0]  cnt_q [NBLK];
  logic              do_wr;
  logic              rd_ok;
  logic [BLK_W-1:0]  nxt_blk;

  assign do_wr   = wr_en && (wr_ptr < CNT_W'(WPB));
  assign nxt_blk = wr_blk + BLK_W'(1);
  assign rd_ok   = rd_idx < CNT_W'(WPB);
  assign rd_word = rd_ok ? mem[rd_blk][rd_idx[IDX_W-1:0]] : '0;
  assign rd_cnt  = cnt_q[rd_blk];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_blk][wr_ptr[IDX_W-1:0]] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_blk <= '0;
      wr_ptr <= '0;
      for (int b = 0; b < NBLK; b++) cnt_q[b] <= '0;
    end else if (clr) begin
      wr_blk <= '0;
      wr_ptr <= '0;
      for (int b = 0; b < NBLK; b++) cnt_q[b] <= '0;
    end else begin
      if (do_wr) begin
        wr_ptr        <= wr_ptr + CNT_W'(1);
        cnt_q[wr_blk] <= wr_ptr + CNT_W'(1);
      end
      if (adv) begin
        wr_blk         <= nxt_blk;
        wr_ptr         <= '0;
        cnt_q[nxt_blk] <= '0;
      end
    end
  end
endmodule

// File: rtl/l1_trig_reader.sv
module l1_trig_reader
  import l1buf_pkg::*;
#(
  parameter int NBLK = 16,
  parameter int WPB  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      trig,
  input  logic [$clog2(NBLK)-1:0]   lat,
  input  logic [$clog2(NBLK)-1:0]   cur_blk,
  input  logic [$clog2(WPB+1)-1:0]  blk_cnt,
  input  logic                      rd_ready,
  output logic [$clog2(NBLK)-1:0]   rd_blk,
  output logic [$clog2(WPB+1)-1:0]  rd_idx,
  output logic                      rd_valid,
  output logic                      busy,
  output logic                      done
);
  localparam int BLK_W = $clog2(NBLK);
  localparam int CNT_W = $clog2(WPB + 1);

  rd_state_e st_q;

  assign busy     = (st_q != RD_IDLE);
  assign rd_valid = busy && (rd_idx < blk_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      rd_blk <= '0;
      rd_idx <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        st_q <= RD_IDLE;
      end else begin
        case (st_q)
          RD_IDLE: begin
            if (trig) begin
              st_q   <= RD_FIRST;
              rd_blk <= cur_blk - lat;
              rd_idx <= '0;
            end
          end
          default: begin
            if (rd_valid) begin
              if (rd_ready) rd_idx <= rd_idx + CNT_W'(1);
            end else if (st_q == RD_FIRST) begin
              st_q   <= RD_SECOND;
              rd_blk <= rd_blk + BLK_W'(1);
              rd_idx <= '0;
            end else begin
              st_q <= RD_IDLE;
              done <= 1'b1;
            end
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/tdc_l1_buffer.sv
module tdc_l1_buffer #(
  parameter int NCH     = 4,
  parameter int TIME_W  = 14,
  parameter int HIT_CAP = 4,
  parameter int NBLK    = 16,
  parameter int WIN_CYC = 256,
  localparam int CH_W   = $clog2(NCH),
  localparam int BLK_W  = $clog2(NBLK),
  localparam int WORD_W = CH_W + TIME_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  spill_start,
  input  logic [NCH-1:0]        hit_vld,
  input  logic [NCH*TIME_W-1:0] hit_time,
  input  logic                  trig,
  input  logic [BLK_W-1:0]      trig_lat,
  input  logic                  rd_ready,
  output logic                  rd_valid,
  output logic [WORD_W-1:0]     rd_data,
  output logic                  rd_busy,
  output logic                  rd_done
);
  localparam int WPB   = NCH * HIT_CAP;
  localparam int CNT_W = $clog2(WPB + 1);
  localparam int WC_W  = $clog2(WIN_CYC);

  logic [WC_W-1:0]   wcyc_q;
  logic [CH_W-1:0]   ph_q;
  logic              boundary;
  logic              load;
  logic              slot_vld;
  logic [TIME_W-1:0] slot_time;
  logic              wr_en;
  logic [BLK_W-1:0]  wr_blk;
  logic [CNT_W-1:0]  wr_ptr;
  logic [BLK_W-1:0]  rd_blk;
  logic [CNT_W-1:0]  rd_idx;
  logic [CNT_W-1:0]  rd_cnt;

  assign boundary = (wcyc_q == WC_W'(WIN_CYC - 1));
  assign load     = (ph_q == CH_W'(NCH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcyc_q <= '0;
      ph_q   <= '0;
    end else if (spill_start) begin
      wcyc_q <= '0;
      ph_q   <= '0;
    end else begin
      wcyc_q <= boundary ? '0 : wcyc_q + WC_W'(1);
      ph_q   <= load ? '0 : ph_q + CH_W'(1);
    end
  end

  l1_hold_shift #(.NCH(NCH), .TIME_W(TIME_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (spill_start),
    .load     (load),
    .in_vld   (hit_vld),
    .in_time  (hit_time),
    .out_vld  (slot_vld),
    .out_time (slot_time)
  );

  l1_hit_limiter #(.NCH(NCH), .HIT_CAP(HIT_CAP)) u_limit (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (spill_start || boundary),
    .slot_vld (slot_vld),
    .slot_ch  (ph_q),
    .wr_en    (wr_en)
  );

  l1_win_store #(.NBLK(NBLK), .WPB(WPB), .WORD_W(WORD_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (spill_start),
    .adv     (boundary),
    .wr_en   (wr_en),
    .wr_word ({ph_q, slot_time}),
    .rd_blk  (rd_blk),
    .rd_idx  (rd_idx),
    .wr_blk  (wr_blk),
    .wr_ptr  (wr_ptr),
    .rd_word (rd_data),
    .rd_cnt  (rd_cnt)
  );

  l1_trig_reader #(.NBLK(NBLK), .WPB(WPB)) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (spill_start),
    .trig     (trig),
    .lat      (trig_lat),
    .cur_blk  (wr_blk),
    .blk_cnt  (rd_cnt),
    .rd_ready (rd_ready),
    .rd_blk   (rd_blk),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .busy     (rd_busy),
    .done     (rd_done)
  );
endmodule

// File: rtl/l1buf_checker.sv
module l1buf_checker #(
  parameter int WPB    = 16,
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WPB + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spill_start,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_busy,
  input logic              rd_done,
  input logic              wr_en,
  input logic [CNT_W-1:0]  wr_ptr
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_ptr < CNT_W'(WPB)));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_busy |-> !rd_valid);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !spill_start) |=> (rd_valid && $stable(rd_data)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |=> !rd_done);

  p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_busy) && !$past(spill_start)) |-> rd_done);

  p_spill_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    spill_start |=> (!rd_busy && !rd_done));
endmodule

bind tdc_l1_buffer l1buf_checker #(.WPB(WPB), .WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .spill_start (spill_start),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data),
  .rd_busy     (rd_busy),
  .rd_done     (rd_done),
  .wr_en       (wr_en),
  .wr_ptr      (wr_ptr)
);

// File: tb/sim_tdc_l1_buffer.sv
module sim_tdc_l1_buffer;
  localparam int NCH  = 4;
  localparam int TW   = 14;
  localparam int NB   = 16;
  localparam int WIN  = 256;
  localparam int NCYC = 20 * WIN;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            spill_start;
  logic [NCH-1:0]  hit_vld;
  logic [NCH*TW-1:0] hit_time;
  logic            trig;
  logic [3:0]      trig_lat;
  logic            rd_ready;
  logic            rd_valid;
  logic [15:0]     rd_data;
  logic            rd_busy;
  logic            rd_done;

  always #2 clk = ~clk;

  tdc_l1_buffer u0 (
    .clk(clk), .rst_n(rst_n), .spill_start(spill_start),
    .hit_vld(hit_vld), .hit_time(hit_time),
    .trig(trig), .trig_lat(trig_lat), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_busy(rd_busy), .rd_done(rd_done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit finished = 0;

  // behavioural reference state
  int          wcyc;
  bit          lv [NCH];
  logic [13:0] lt [NCH];
  int          hcnt [NCH];
  logic [15:0] mq [NB][$];
  int          wb;
  bit          ract;
  int          rhalf, rblk, ridx;
  bit          mdone;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cycle %0d: actual=%0h expected=%0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic model_clear();
    wcyc = 0; wb = 0; ract = 0; rhalf = 0; rblk = 0; ridx = 0; mdone = 0;
    for (int c = 0; c < NCH; c++) begin lv[c] = 0; lt[c] = '0; hcnt[c] = 0; end
    for (int b = 0; b < NB; b++) mq[b].delete();
  endtask

  function automatic bit exp_valid();
    return ract && (ridx < mq[rblk].size());
  endfunction

  task automatic model_step();
    bit rv;
    int ph;
    if (spill_start) begin model_clear(); return; end
    ph = wcyc % 4;
    rv = exp_valid();
    mdone = 0;
    if (!ract) begin
      if (trig) begin
        ract = 1; rhalf = 0; ridx = 0;
        rblk = (wb - int'(trig_lat) + NB) % NB;
      end
    end else if (rv) begin
      if (rd_ready) ridx++;
    end else if (rhalf == 0) begin
      rhalf = 1; rblk = (rblk + 1) % NB; ridx = 0;
    end else begin
      ract = 0; mdone = 1;
    end
    if (lv[ph] && hcnt[ph] < 4) begin
      mq[wb].push_back({2'(ph), lt[ph]});
      hcnt[ph]++;
    end
    if (ph == 3) begin
      for (int c = 0; c < NCH; c++) begin
        lv[c] = hit_vld[c];
        lt[c] = hit_time[c*TW +: TW];
      end
    end
    if (wcyc == WIN - 1) begin
      wcyc = 0;
      wb = (wb + 1) % NB;
      mq[wb].delete();
      for (int c = 0; c < NCH; c++) hcnt[c] = 0;
    end else begin
      wcyc++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R6 watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    int lats [5];
    string tag;
    lats[0] = 2; lats[1] = 3; lats[2] = 7; lats[3] = 14; lats[4] = 1;
    lfsr = 32'h1ACE_B00C;
    rst_n = 0; spill_start = 0; hit_vld = '0; hit_time = '0;
    trig = 0; trig_lat = '0; rd_ready = 1;
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "busy", rd_busy, 0);
    check("R1", "valid", rd_valid, 0);
    check("R1", "done", rd_done, 0);
    rst_n = 1;
    for (int n = 0; n < NCYC; n++) begin
      int w;
      w = n / WIN;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (w < 4)       tag = "R3";
      else if (w < 6)  tag = "R2";
      else if (w < 12) tag = "R7";
      else if (w < 14) tag = "R10";
      else             tag = "R5";
      // hit stimulus
      if (w < 4)      hit_vld = lfsr[3:0];
      else if (w < 6) hit_vld = (wcyc % 4 == 3) ? 4'h0 : 4'hF;
      else            hit_vld = lfsr[3:0] & lfsr[7:4] & lfsr[11:8];
      for (int c = 0; c < NCH; c++)
        hit_time[c*TW +: TW] = TW'(n * 3 + c * 4099 + int'(lfsr[9:0]));
      rd_ready = (w >= 6 && w < 12) ? (lfsr[13:12] != 2'b00) : 1'b1;
      // triggers: second one at +15 lands while busy (R9)
      trig = (w >= 6) && ((n % 97 == 5) || (n % 97 == 20) || (n == 12*WIN + 30));
      trig_lat = 4'(lats[(n / 97) % 5]);
      spill_start = (n == 12*WIN + 40);
      model_step();
      @(negedge clk);
      cyc = n;
      check(tag, "R9 busy", rd_busy, ract);
      check(tag, "R6 valid", rd_valid, exp_valid());
      check(tag, "R8 done", rd_done, mdone);
      if (exp_valid()) check(tag, "R4 data", rd_data, mq[rblk][ridx]);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule